// File: doc/BRIEF.md
# Extended wait-cycle insertion unit

This unit lengthens the strobe phase of an asynchronous external-memory access for as long as a slow device signals that it is not ready. It watches four external wait pins and serves four chip-select spaces. Each space is mapped to one of the four pins through a small per-space field. Each pin has its own active level. A programmable ceiling bounds the stretch, so a device whose wait pin is stuck cannot hang the bus.

The access sequencer raises `strobe_end` in the last cycle of the programmed strobe width. It also presents the space being accessed and the per-space stretch enables. If stretching is enabled for that space and the mapped wait pin is active, `hold_strobe` rises in that same cycle. The sequencer then stays in strobe while `hold_strobe` is high. If the ceiling is reached first, a one-cycle `timeout` pulse reports it. Pin polarity, the pin map and the ceiling are loaded through a single-cycle configuration strobe. The wait pins are resynchronised inside the unit.

Top module: `ewait_stretch`

## Requirements
- R1: After reset, every pin is active-high (polarity bits all 1). Space s watches pin s (map field for space s at bits [2s+1:2s] holds s). The ceiling is 128 (0x80). `hold_strobe` and `timeout` are 0.
- R2: A pin is active when its synchronised level equals its polarity bit: polarity bit p = 1 means active-high and polarity bit p = 0 means active-low.
- R3: Space s uses the pin whose index (0 to 3) is held in `cfg_map[2s+1:2s]`.
- R4: A change on a wait pin takes part in decisions from the second rising edge after it is first sampled. The pin passes through two flops.
- R5: When the enable bit `ew_en[space_idx]` is 0, `hold_strobe` stays 0 whatever the wait pins do.
- R6: In an idle cycle, `hold_strobe` is 1 in the same cycle when `strobe_end` is 1, stretching is enabled for the space and its pin is active, provided the ceiling is non-zero.
- R7: Once stretching, `hold_strobe` stays 1 up to and including the first cycle in which the mapped pin is seen inactive. It then drops, with no timeout.
- R8: If the pin stays active, `hold_strobe` is high for exactly ceiling+1 consecutive cycles. `timeout` is then 1 for the single following cycle.
- R9: With a ceiling of 0, an active start request produces no `hold_strobe`, and `timeout` is 1 in the following cycle.
- R10: Values on the configuration inputs take effect from the cycle after `cfg_load` is 1. While `cfg_load` is 0, they are kept.
- R11: The space is captured when stretching starts. While stretching, changes on `space_idx` and further `strobe_end` pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Load the configuration inputs |
| cfg_pol | input | 4 | Active level per wait pin (1 = high) |
| cfg_map | input | 8 | Pin index per space, 2 bits each, space 0 in the low bits |
| cfg_max | input | 8 | Stretch ceiling in cycles |
| wait_pin | input | 4 | Raw external wait pins |
| strobe_end | input | 1 | Last programmed strobe cycle of the current access |
| space_idx | input | 2 | Space of the current access |
| ew_en | input | 4 | Stretch enable per space |
| hold_strobe | output | 1 | Keep the sequencer in strobe this cycle |
| timeout | output | 1 | One-cycle pulse: the ceiling ended the stretch |

## Verification
`hold_strobe` is a same-cycle result of `strobe_end` and the registered state. `timeout` is due one cycle after the last held cycle. A pin edge is seen two rising edges after it is applied, and a configuration load applies from the next cycle. The bench drives every input at the falling edge and compares both outputs 1 ns later, before the next rising edge. It compares them against a cycle model that follows these latencies. Therefore each sample sees exactly one rising edge's worth of update.

// File: rtl/ewait_pkg.sv
package ewait_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ew_state_e;
endpackage

// File: rtl/ewait_sync.sv
module ewait_sync #(
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_raw,
    output logic [NUM_PINS-1:0] pin_sync
);
    typedef struct packed {
        logic [NUM_PINS-1:0] meta;
        logic [NUM_PINS-1:0] stable;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = pin_raw;
        sync_d.stable = sync_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign pin_sync = sync_q.stable;
endmodule

// File: rtl/ewait_cfg.sv
module ewait_cfg #(
    parameter int NUM_PINS   = 4,
    parameter int NUM_SPACES = 4,
    parameter int PIN_W      = 2,
    parameter int CNT_W      = 8,
    parameter int MAX_RST    = 128
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_load,
    input  logic [NUM_PINS-1:0]         cfg_pol,
    input  logic [NUM_SPACES*PIN_W-1:0] cfg_map,
    input  logic [CNT_W-1:0]            cfg_max,
    output logic [NUM_PINS-1:0]         pol_q,
    output logic [NUM_SPACES*PIN_W-1:0] map_q,
    output logic [CNT_W-1:0]            max_q
);
    localparam int MAP_W = NUM_SPACES * PIN_W;

    function automatic logic [MAP_W-1:0] default_map();
        logic [MAP_W-1:0] m;
        m = '0;
        for (int s = 0; s < NUM_SPACES; s++) begin
            m[s*PIN_W +: PIN_W] = PIN_W'(s % NUM_PINS);
        end
        return m;
    endfunction

    localparam logic [MAP_W-1:0] MAP_RST = default_map();

    typedef struct packed {
        logic [NUM_PINS-1:0] pol;
        logic [MAP_W-1:0]    map;
        logic [CNT_W-1:0]    max;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_load) begin
            cfg_d.pol = cfg_pol;
            cfg_d.map = cfg_map;
            cfg_d.max = cfg_max;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{pol: '1, map: MAP_RST, max: CNT_W'(MAX_RST)};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign pol_q = cfg_q.pol;
    assign map_q = cfg_q.map;
    assign max_q = cfg_q.max;

    AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> ($stable(pol_q) && $stable(map_q) && $stable(max_q))); // R10
    AST_CFG_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (pol_q == $past(cfg_pol) && max_q == $past(cfg_max))); // R10
endmodule

// File: rtl/ewait_select.sv
module ewait_select #(
    parameter int NUM_PINS   = 4,
    parameter int NUM_SPACES = 4,
    parameter int PIN_W      = 2,
    parameter int SP_W       = 2
) (
    input  logic [NUM_PINS-1:0]         pin_sync,
    input  logic [NUM_PINS-1:0]         pol,
    input  logic [NUM_SPACES*PIN_W-1:0] map,
    input  logic [SP_W-1:0]             sel_space,
    output logic                        wait_act
);
    logic [PIN_W-1:0]    field [NUM_SPACES];
    logic [NUM_PINS-1:0] pin_act;

    for (genvar s = 0; s < NUM_SPACES; s++) begin : g_field
        assign field[s] = map[s*PIN_W +: PIN_W];
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pol
        assign pin_act[p] = (pin_sync[p] == pol[p]);
    end

    always_comb begin
        wait_act = pin_act[field[sel_space]];
    end
endmodule

// File: rtl/ewait_fsm.sv
module ewait_fsm
    import ewait_pkg::*;
#(
    parameter int NUM_SPACES = 4,
    parameter int SP_W       = 2,
    parameter int CNT_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strobe_end,
    input  logic [SP_W-1:0]       space_idx,
    input  logic [NUM_SPACES-1:0] ew_en,
    input  logic                  wait_act,
    input  logic [CNT_W-1:0]      max_cnt,
    output logic [SP_W-1:0]       sel_space,
    output logic                  hold_strobe,
    output logic                  timeout
);
    typedef struct packed {
        ew_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic [SP_W-1:0]  space;
        logic             tout;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic entry_req;
    logic max_zero;

    always_comb begin
        max_zero  = (max_cnt == '0);
        sel_space = (fsm_q.state == ST_IDLE) ? space_idx : fsm_q.space;
        entry_req = (fsm_q.state == ST_IDLE) && strobe_end && ew_en[space_idx] && wait_act;

        fsm_d      = fsm_q;
        fsm_d.tout = 1'b0;
        case (fsm_q.state)
            ST_IDLE: begin
                if (entry_req) begin
                    if (max_zero) begin
                        fsm_d.tout = 1'b1;
                    end else begin
                        fsm_d.state = ST_WAIT;
                        fsm_d.cnt   = CNT_W'(1);
                        fsm_d.space = space_idx;
                    end
                end
            end
            ST_WAIT: begin
                if (!wait_act) begin
                    fsm_d.state = ST_IDLE;
                end else if (fsm_q.cnt >= max_cnt) begin
                    fsm_d.state = ST_IDLE;
                    fsm_d.tout  = 1'b1;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + CNT_W'(1);
                end
            end
            default: fsm_d.state = ST_IDLE;
        endcase

        hold_strobe = (fsm_q.state == ST_WAIT) || (entry_req && !max_zero);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_IDLE, cnt: '0, space: '0, tout: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign timeout = fsm_q.tout;

    AST_DISABLED_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_IDLE && !ew_en[space_idx]) |-> !hold_strobe); // R5
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_WAIT && !wait_act) |=> (fsm_q.state == ST_IDLE && !timeout)); // R7
    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_WAIT) |-> (fsm_q.cnt != '0)); // R8
    AST_TIMEOUT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> ($past(fsm_q.state) == ST_WAIT || $past(max_cnt) == '0)); // R9
    AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && $past(fsm_q.state) == ST_WAIT) |-> (fsm_q.state == ST_IDLE)); // R8
    AST_ENTRY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_req && !max_zero) |=> (fsm_q.state == ST_WAIT && fsm_q.space == $past(space_idx))); // R11
endmodule

// File: rtl/ewait_stretch.sv
module ewait_stretch #(
    parameter int NUM_PINS   = 4,
    parameter int NUM_SPACES = 4,
    parameter int CNT_W      = 8,
    parameter int MAX_RST    = 128
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     cfg_load,
    input  logic [NUM_PINS-1:0]                      cfg_pol,
    input  logic [NUM_SPACES*$clog2(NUM_PINS)-1:0]   cfg_map,
    input  logic [CNT_W-1:0]                         cfg_max,
    input  logic [NUM_PINS-1:0]                      wait_pin,
    input  logic                                     strobe_end,
    input  logic [$clog2(NUM_SPACES)-1:0]            space_idx,
    input  logic [NUM_SPACES-1:0]                    ew_en,
    output logic                                     hold_strobe,
    output logic                                     timeout
);
    localparam int PIN_W = $clog2(NUM_PINS);
    localparam int SP_W  = $clog2(NUM_SPACES);
    localparam int MAP_W = NUM_SPACES * PIN_W;

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] pol_q;
    logic [MAP_W-1:0]    map_q;
    logic [CNT_W-1:0]    max_q;
    logic [SP_W-1:0]     sel_space;
    logic                wait_act;

    ewait_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (wait_pin),
        .pin_sync (pin_sync)
    );

    ewait_cfg #(
        .NUM_PINS   (NUM_PINS),
        .NUM_SPACES (NUM_SPACES),
        .PIN_W      (PIN_W),
        .CNT_W      (CNT_W),
        .MAX_RST    (MAX_RST)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_pol  (cfg_pol),
        .cfg_map  (cfg_map),
        .cfg_max  (cfg_max),
        .pol_q    (pol_q),
        .map_q    (map_q),
        .max_q    (max_q)
    );

    ewait_select #(
        .NUM_PINS   (NUM_PINS),
        .NUM_SPACES (NUM_SPACES),
        .PIN_W      (PIN_W),
        .SP_W       (SP_W)
    ) u_select (
        .pin_sync  (pin_sync),
        .pol       (pol_q),
        .map       (map_q),
        .sel_space (sel_space),
        .wait_act  (wait_act)
    );

    ewait_fsm #(
        .NUM_SPACES (NUM_SPACES),
        .SP_W       (SP_W),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_end  (strobe_end),
        .space_idx   (space_idx),
        .ew_en       (ew_en),
        .wait_act    (wait_act),
        .max_cnt     (max_q),
        .sel_space   (sel_space),
        .hold_strobe (hold_strobe),
        .timeout     (timeout)
    );
endmodule

// File: tb/ewait_stretch_tb.sv
module ewait_stretch_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic [3:0] cfg_pol = 4'hF;
    logic [7:0] cfg_map = 8'h00;
    logic [7:0] cfg_max = 8'h00;
    logic [3:0] wait_pin = 4'h0;
    logic       strobe_end = 1'b0;
    logic [1:0] space_idx = 2'd0;
    logic [3:0] ew_en = 4'h0;
    logic       hold_strobe;
    logic       timeout;

    always #2.5 clk = ~clk;

    ewait_stretch dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_pol(cfg_pol),
        .cfg_map(cfg_map), .cfg_max(cfg_max), .wait_pin(wait_pin),
        .strobe_end(strobe_end), .space_idx(space_idx), .ew_en(ew_en),
        .hold_strobe(hold_strobe), .timeout(timeout)
    );

    // staged stimulus, applied at the next falling edge
    bit       t_load;
    bit [3:0] t_pol;
    bit [7:0] t_map;
    bit [7:0] t_max;
    bit [3:0] t_pin;
    bit       t_se;
    bit [1:0] t_si;
    bit [3:0] t_en;

    // reference model state
    bit [3:0] m_pol = 4'hF;
    bit [7:0] m_map = 8'b11_10_01_00;
    bit [7:0] m_max = 8'd128;
    bit [3:0] m_s1, m_s2;
    bit       m_wait;
    bit [7:0] m_cnt;
    bit [1:0] m_sp;
    bit       m_tout;

    int    nchk = 0;
    int    nfail = 0;
    bit    done = 0;
    string cur_req = "R1";

    function automatic bit m_act(bit [1:0] sp);
        int p;
        p = int'(m_map[sp*2 +: 2]);
        return m_s2[p] == m_pol[p];
    endfunction

    task automatic chk(bit got, bit exp, string what);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0b expected=%0b", cur_req, what, got, exp);
        end
    endtask

    task automatic tick();
        bit req, e_hold, nt;
        @(negedge clk);
        cfg_load = t_load; cfg_pol = t_pol; cfg_map = t_map; cfg_max = t_max;
        wait_pin = t_pin; strobe_end = t_se; space_idx = t_si; ew_en = t_en;
        #1;
        req    = !m_wait && t_se && t_en[t_si] && m_act(t_si);
        e_hold = m_wait || (req && m_max != 0);
        chk(hold_strobe, e_hold, "hold_strobe");
        chk(timeout, m_tout, "timeout");
        nt = 0;
        if (!m_wait) begin
            if (req) begin
                if (m_max == 0) nt = 1;
                else begin m_wait = 1; m_cnt = 1; m_sp = t_si; end
            end
        end else begin
            if (!m_act(m_sp)) m_wait = 0;
            else if (m_cnt >= m_max) begin m_wait = 0; nt = 1; end
            else m_cnt = m_cnt + 1;
        end
        m_tout = nt;
        if (t_load) begin m_pol = t_pol; m_map = t_map; m_max = t_max; end
        m_s2 = m_s1;
        m_s1 = t_pin;
        t_load = 0;
    endtask

    task automatic idle(int n);
        t_se = 0;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic load(bit [3:0] pol, bit [7:0] map, bit [7:0] mx);
        t_pol = pol; t_map = map; t_max = mx; t_load = 1;
        tick();
    endtask

    task automatic start(bit [1:0] sp);
        t_si = sp; t_se = 1;
        tick();
        t_se = 0;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int r;
        r = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset outputs
        cur_req = "R1";
        chk(hold_strobe, 1'b0, "reset hold_strobe");
        chk(timeout, 1'b0, "reset timeout");
        t_en = 4'hF;
        // R1: default ceiling 128 and default pin 0 for space 0, active high
        t_pin = 4'b0001; idle(3);
        start(2'd0); idle(135);
        // R1: default map space 3 -> pin 3, released early (R7)
        t_pin = 4'b1000; idle(3);
        cur_req = "R7";
        start(2'd3); idle(4);
        t_pin = 4'b0000; idle(6);
        // R10/R3: space 0 remapped to pin 3, ceiling 3 (R8)
        cur_req = "R10";
        load(4'hF, 8'b00_01_10_11, 8'd3);
        cur_req = "R3";
        t_pin = 4'b1000; idle(3);
        start(2'd0); idle(8);
        cur_req = "R8";
        start(2'd0); idle(8);
        // R2: pin 1 active low for space 1
        cur_req = "R2";
        load(4'b1101, 8'b11_10_01_00, 8'd20);
        t_pin = 4'b0000; idle(3);
        start(2'd1); idle(5);
        t_pin = 4'b0010; idle(6);
        // R5: enable clear for space 1
        cur_req = "R5";
        t_pin = 4'b0000; idle(3);
        t_en = 4'b1101;
        start(2'd1); idle(4);
        t_en = 4'hF;
        // R9: ceiling 0
        cur_req = "R9";
        load(4'b1101, 8'b11_10_01_00, 8'd0);
        start(2'd1); idle(4);
        // R11: space change and extra strobe_end during wait
        cur_req = "R11";
        load(4'hF, 8'b11_10_01_00, 8'd10);
        t_pin = 4'b0001; idle(3);
        start(2'd0);
        t_si = 2'd2; t_se = 1; tick(); tick();
        t_se = 0; idle(12);
        // R4: pin rising together with strobe_end is not yet seen
        cur_req = "R4";
        t_pin = 4'b0000; idle(3);
        t_pin = 4'b0100; start(2'd2);
        tick(); start(2'd2); idle(14);
        // R6: random mix
        cur_req = "R6";
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 64) == 0)
                load(4'($urandom), 8'($urandom), 8'($urandom % 7));
            else begin
                if (($urandom % 4) == 0) t_pin = 4'($urandom);
                t_se = (($urandom % 5) == 0);
                t_si = 2'($urandom);
                t_en = 4'($urandom) | 4'b0101;
                tick();
            end
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule